// File: doc/BRIEF.md
# Multi-class register rename map

This block translates architectural register numbers into physical register tags for an out-of-order core. It keeps three independent map tables, one each for the integer, floating-point and condition-code classes. Each table draws fresh tags from a free list of its own, which is a small circular FIFO inside the block. A fourth class, misc, is hard-wired: its registers are never renamed, and each misc index is its own tag.

Callers use one class-tagged interface. A rename request allocates a new tag and returns it one cycle later, together with the tag it displaced, so that commit can release the displaced tag later. A lookup reads a mapping combinationally and changes nothing. A set-entry request lets commit or squash logic write a mapping back directly. A per-class free port returns released tags to the tail of that class's free list. Each class has a designated zero register, which is never reallocated. The condition-code class has no zero register.

Top module: `rrm_top`

## Requirements
- R1: After reset, index i of the integer, floating-point and condition-code classes maps to tag i. Each class's free list holds the tags from the class's architectural count up to its physical count minus one, in ascending order. Defaults: integer 8 registers with 16 tags, floating-point 8 with 12, condition-code 4 with 6, misc 4.
- R2: An accepted rename raises `renDone` on the following cycle. In that cycle `renNewTag` is the head of the class's free list and `renPrevTag` is the mapping the index held before the request. The map entry then holds the new tag.
- R3: A rename of a class's zero register (integer index 0, floating-point index 7) consumes no free tag and leaves the map unchanged. It returns the current mapping as both tags, and it never stalls, even when the free list is empty.
- R4: The condition-code class has no zero register, so every condition-code index allocates a fresh tag.
- R5: Each class has its own map and free list. A rename, set or free in one class leaves the mappings and free tags of the other classes untouched.
- R6: Misc registers are never renamed. A misc rename returns the index as both tags without stalling, and a misc lookup returns the index. A misc set-entry whose tag equals the index changes nothing; one whose tag differs raises `errFlag` on the next cycle.
- R7: A lookup returns the current mapping combinationally and alters no state. When a rename and a lookup address the same entry in the same cycle, the lookup returns the mapping from before the rename.
- R8: A set-entry request overwrites the addressed mapping at the next clock edge. If a rename writes the same entry in the same cycle, the set-entry value wins.
- R9: Class codes are 0 integer, 1 floating-point, 2 condition-code and 3 misc. A valid rename, lookup or set-entry carrying a code from 4 to 7 raises `errFlag` on the next cycle. A rename with such a code produces no `renDone` and changes no state.
- R10: A rename of a non-zero register whose class free list is empty raises `renStall` in the same cycle. It produces no `renDone` and leaves the map and free list unchanged.
- R11: A tag presented on a class's free port is appended to that class's free list, and later renames receive freed tags in the order they were freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | Rename request strobe |
| renClass | input | 3 | Rename class code |
| renIdx | input | IDX_W | Architectural index to rename |
| renStall | output | 1 | Rename cannot proceed this cycle (combinational) |
| renDone | output | 1 | Rename result valid (one cycle after acceptance) |
| renNewTag | output | TAG_W | Newly assigned physical tag |
| renPrevTag | output | TAG_W | Tag displaced by the rename |
| lkValid | input | 1 | Lookup strobe (used for class-code checking only) |
| lkClass | input | 3 | Lookup class code |
| lkIdx | input | IDX_W | Lookup index |
| lkTag | output | TAG_W | Current mapping (combinational) |
| setValid | input | 1 | Set-entry strobe |
| setClass | input | 3 | Set-entry class code |
| setIdx | input | IDX_W | Set-entry index |
| setTag | input | TAG_W | Tag to write |
| freeValid | input | 3 | Per-class free strobe (bit 0 integer, 1 floating-point, 2 condition-code) |
| freeTag | input | 3 x TAG_W | Per-class tag being freed |
| errFlag | output | 1 | Fatal request error (one cycle after the request) |

## Verification
The bench drains each class's free list to empty and checks the stall at that point. A design that looked at the wrong class's list, or that popped on a stall, would hand out a tag that does not exist or would corrupt the map. It renames each zero register while its list is empty. A design that handled the zero register like any other index would stall, or would reallocate a register that must stay fixed. It drives a same-cycle rename and lookup to the same entry, and a same-cycle rename and set-entry. A write-through lookup, or the wrong write priority, would leave the wrong mapping behind after a squash. It also checks that freed tags come back in FIFO order and that misc and bad class codes leave all three maps untouched.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

  localparam int NUM_MAP_CLS = 3;

  typedef enum logic [2:0] {
    CLS_INT  = 3'd0,
    CLS_FP   = 3'd1,
    CLS_CC   = 3'd2,
    CLS_MISC = 3'd3
  } rrmCls_e;

  // Strobes from control to datapath and free lists
  typedef struct packed {
    logic [NUM_MAP_CLS-1:0] allocCls; // pop free list + write map, per class
    logic [NUM_MAP_CLS-1:0] setCls;   // direct map write, per class
    logic                   accept;   // rename result is produced next cycle
    logic                   errReq;   // fatal request seen this cycle
  } rrmStrobe_t;

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rrm_freelist.sv
module rrm_freelist #(
  parameter int DEPTH = 8,
  parameter int BASE  = 8,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pop,
  input  logic             push,
  input  logic [TAG_W-1:0] pushTag,
  output logic [TAG_W-1:0] head,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [PW-1:0]    rdPtr, wrPtr;
  logic [CW-1:0]    count;

  function automatic logic [PW-1:0] nextPtr(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= TAG_W'(BASE + k);
      rdPtr <= '0;
      wrPtr <= '0;
      count <= CW'(DEPTH);
    end else begin
      if (push) begin
        mem[wrPtr] <= pushTag;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (pop) rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head  = mem[rdPtr];
  assign empty = (count == '0);

  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |-> (count < CW'(DEPTH)));

endmodule

// File: rtl/rrm_ctrl.sv
module rrm_ctrl
  import rrm_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int TAG_W   = 4,
  parameter int INT_ZERO = 0,
  parameter int FP_ZERO  = 7,
  parameter int CC_ZERO  = -1
) (
  input  logic                   renValid,
  input  logic [2:0]             renClass,
  input  logic [IDX_W-1:0]       renIdx,
  input  logic                   lkValid,
  input  logic [2:0]             lkClass,
  input  logic                   setValid,
  input  logic [2:0]             setClass,
  input  logic [IDX_W-1:0]       setIdx,
  input  logic [TAG_W-1:0]       setTag,
  input  logic [NUM_MAP_CLS-1:0] flEmpty,
  output rrmStrobe_t             strobe,
  output logic                   renStall
);
  logic zeroHit, needAlloc, miscBad;

  always_comb begin
    unique case (renClass)
      CLS_INT: zeroHit = (int'(renIdx) == INT_ZERO);
      CLS_FP:  zeroHit = (int'(renIdx) == FP_ZERO);
      CLS_CC:  zeroHit = (int'(renIdx) == CC_ZERO);
      default: zeroHit = 1'b0;
    endcase

    needAlloc = renValid && (renClass < 3'd3) && !zeroHit;
    renStall  = needAlloc && flEmpty[renClass[1:0]];

    strobe.allocCls = '0;
    if (needAlloc && !renStall) strobe.allocCls[renClass[1:0]] = 1'b1;
    strobe.accept = renValid && (renClass <= 3'd3) && !renStall;

    strobe.setCls = '0;
    if (setValid && (setClass < 3'd3)) strobe.setCls[setClass[1:0]] = 1'b1;

    miscBad = setValid && (setClass == CLS_MISC) && (setTag != TAG_W'(setIdx));
    strobe.errReq = (renValid && renClass > 3'd3) || (lkValid && lkClass > 3'd3) ||
                    (setValid && setClass > 3'd3) || miscBad;
  end

endmodule

// File: rtl/rrm_datapath.sv
module rrm_datapath
  import rrm_pkg::*;
#(
  parameter int INT_ARCH = 8,
  parameter int FP_ARCH  = 8,
  parameter int CC_ARCH  = 4,
  parameter int IDX_W    = 3,
  parameter int TAG_W    = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  rrmStrobe_t                         strobe,
  input  logic [2:0]                         renClass,
  input  logic [IDX_W-1:0]                   renIdx,
  input  logic [NUM_MAP_CLS-1:0][TAG_W-1:0]  flHead,
  input  logic [2:0]                         lkClass,
  input  logic [IDX_W-1:0]                   lkIdx,
  input  logic [IDX_W-1:0]                   setIdx,
  input  logic [TAG_W-1:0]                   setTag,
  output logic                               renDone,
  output logic [TAG_W-1:0]                   renNewTag,
  output logic [TAG_W-1:0]                   renPrevTag,
  output logic                               errFlag,
  output logic [TAG_W-1:0]                   lkTag
);
  logic [TAG_W-1:0] renRd [NUM_MAP_CLS];
  logic [TAG_W-1:0] lkRd  [NUM_MAP_CLS];
  logic [TAG_W-1:0] curTag, newTag;

  for (genvar c = 0; c < NUM_MAP_CLS; c++) begin : g_map
    localparam int N  = (c == 0) ? INT_ARCH : (c == 1) ? FP_ARCH : CC_ARCH;
    localparam int IW = $clog2(N);
    logic [TAG_W-1:0] tbl [N];

    assign renRd[c] = tbl[renIdx[IW-1:0]];
    assign lkRd[c]  = tbl[lkIdx[IW-1:0]];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < N; i++) tbl[i] <= TAG_W'(i);
      end else begin
        for (int i = 0; i < N; i++) begin
          if (strobe.setCls[c] && setIdx == IDX_W'(i))
            tbl[i] <= setTag;                 // restore wins over rename
          else if (strobe.allocCls[c] && renIdx == IDX_W'(i))
            tbl[i] <= flHead[c];
        end
      end
    end
  end

  always_comb begin
    unique case (renClass)
      CLS_INT:  curTag = renRd[0];
      CLS_FP:   curTag = renRd[1];
      CLS_CC:   curTag = renRd[2];
      CLS_MISC: curTag = TAG_W'(renIdx);
      default:  curTag = '0;
    endcase
    newTag = (|strobe.allocCls) ? flHead[renClass[1:0]] : curTag;

    unique case (lkClass)
      CLS_INT:  lkTag = lkRd[0];
      CLS_FP:   lkTag = lkRd[1];
      CLS_CC:   lkTag = lkRd[2];
      CLS_MISC: lkTag = TAG_W'(lkIdx);
      default:  lkTag = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      renDone    <= 1'b0;
      errFlag    <= 1'b0;
      renNewTag  <= '0;
      renPrevTag <= '0;
    end else begin
      renDone <= strobe.accept;
      errFlag <= strobe.errReq;
      if (strobe.accept) begin
        renNewTag  <= newTag;
        renPrevTag <= curTag;
      end
    end
  end

endmodule

// File: rtl/rrm_top.sv
module rrm_top
  import rrm_pkg::*;
#(
  parameter int INT_ARCH = 8,
  parameter int INT_PHYS = 16,
  parameter int FP_ARCH  = 8,
  parameter int FP_PHYS  = 12,
  parameter int CC_ARCH  = 4,
  parameter int CC_PHYS  = 6,
  parameter int MISC_N   = 4,
  parameter int INT_ZERO = 0,
  parameter int FP_ZERO  = 7,
  parameter int CC_ZERO  = -1,
  parameter int IDX_W = $clog2(maxOf(maxOf(INT_ARCH, FP_ARCH), maxOf(CC_ARCH, MISC_N))),
  parameter int TAG_W = $clog2(maxOf(maxOf(INT_PHYS, FP_PHYS), CC_PHYS))
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              renValid,
  input  logic [2:0]                        renClass,
  input  logic [IDX_W-1:0]                  renIdx,
  output logic                              renStall,
  output logic                              renDone,
  output logic [TAG_W-1:0]                  renNewTag,
  output logic [TAG_W-1:0]                  renPrevTag,
  input  logic                              lkValid,
  input  logic [2:0]                        lkClass,
  input  logic [IDX_W-1:0]                  lkIdx,
  output logic [TAG_W-1:0]                  lkTag,
  input  logic                              setValid,
  input  logic [2:0]                        setClass,
  input  logic [IDX_W-1:0]                  setIdx,
  input  logic [TAG_W-1:0]                  setTag,
  input  logic [2:0]                        freeValid,
  input  logic [2:0][TAG_W-1:0]             freeTag,
  output logic                              errFlag
);
  rrmStrobe_t                        strobe;
  logic [NUM_MAP_CLS-1:0]            flEmpty;
  logic [NUM_MAP_CLS-1:0][TAG_W-1:0] flHead;

  for (genvar c = 0; c < NUM_MAP_CLS; c++) begin : g_fl
    localparam int A = (c == 0) ? INT_ARCH : (c == 1) ? FP_ARCH : CC_ARCH;
    localparam int P = (c == 0) ? INT_PHYS : (c == 1) ? FP_PHYS : CC_PHYS;
    rrm_freelist #(.DEPTH(P - A), .BASE(A), .TAG_W(TAG_W)) u_fl (
      .clk(clk), .rstN(rstN),
      .pop(strobe.allocCls[c]), .push(freeValid[c]), .pushTag(freeTag[c]),
      .head(flHead[c]), .empty(flEmpty[c])
    );
  end

  rrm_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .INT_ZERO(INT_ZERO),
             .FP_ZERO(FP_ZERO), .CC_ZERO(CC_ZERO)) u_ctrl (
    .renValid(renValid), .renClass(renClass), .renIdx(renIdx),
    .lkValid(lkValid), .lkClass(lkClass),
    .setValid(setValid), .setClass(setClass), .setIdx(setIdx), .setTag(setTag),
    .flEmpty(flEmpty), .strobe(strobe), .renStall(renStall)
  );

  rrm_datapath #(.INT_ARCH(INT_ARCH), .FP_ARCH(FP_ARCH), .CC_ARCH(CC_ARCH),
                 .IDX_W(IDX_W), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .renClass(renClass), .renIdx(renIdx), .flHead(flHead),
    .lkClass(lkClass), .lkIdx(lkIdx), .setIdx(setIdx), .setTag(setTag),
    .renDone(renDone), .renNewTag(renNewTag), .renPrevTag(renPrevTag),
    .errFlag(errFlag), .lkTag(lkTag)
  );

  p_stall_no_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    renStall |=> !renDone);
  p_bad_class_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && renClass > 3'd3) |=> (errFlag && !renDone));
  p_zero_same_r3: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && renClass == 3'd0 && int'(renIdx) == INT_ZERO) |=>
      (renDone && renNewTag == renPrevTag));
  p_misc_ident_r6: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && renClass == 3'd3) |=>
      (renDone && renNewTag == TAG_W'($past(renIdx)) && renPrevTag == TAG_W'($past(renIdx))));

endmodule

// File: tb/rrm_top_bench.sv
module rrm_top_bench;
  localparam int IDX_W = 3;
  localparam int TAG_W = 4;
  localparam int ARCH [4] = '{8, 8, 4, 4};
  localparam int PHYS [3] = '{16, 12, 6};
  localparam int ZERO [3] = '{0, 7, -1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic renValid = 1'b0, lkValid = 1'b0, setValid = 1'b0;
  logic [2:0] renClass = '0, lkClass = '0, setClass = '0;
  logic [IDX_W-1:0] renIdx = '0, lkIdx = '0, setIdx = '0;
  logic [TAG_W-1:0] setTag = '0;
  logic [2:0] freeValid = '0;
  logic [2:0][TAG_W-1:0] freeTag = '0;
  logic renStall, renDone, errFlag;
  logic [TAG_W-1:0] renNewTag, renPrevTag, lkTag;

  rrm_top u_rrm_top (
    .clk(clk), .rstN(rstN),
    .renValid(renValid), .renClass(renClass), .renIdx(renIdx),
    .renStall(renStall), .renDone(renDone), .renNewTag(renNewTag), .renPrevTag(renPrevTag),
    .lkValid(lkValid), .lkClass(lkClass), .lkIdx(lkIdx), .lkTag(lkTag),
    .setValid(setValid), .setClass(setClass), .setIdx(setIdx), .setTag(setTag),
    .freeValid(freeValid), .freeTag(freeTag), .errFlag(errFlag)
  );

  always #2 clk = ~clk;

  int nChecks = 0, nFail = 0;
  int mdl [3][8];
  int qi[$], qf[$], qc[$];

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int qsize(int c);
    return (c == 0) ? qi.size() : (c == 1) ? qf.size() : qc.size();
  endfunction
  function automatic int qpop(int c);
    if (c == 0) return qi.pop_front();
    if (c == 1) return qf.pop_front();
    return qc.pop_front();
  endfunction
  function automatic void qpush(int c, int v);
    if (c == 0) qi.push_back(v);
    else if (c == 1) qf.push_back(v);
    else qc.push_back(v);
  endfunction

  task automatic doRen(string req, int c, int i);
    int expN = 0, expP = 0, expStall = 0, expDone = 1, expErr = 0;
    @(negedge clk);
    renValid = 1'b1; renClass = 3'(c); renIdx = IDX_W'(i);
    #1;
    if (c == 3) begin expN = i; expP = i; end
    else if (c > 3) begin expDone = 0; expErr = 1; end
    else if (i == ZERO[c]) begin expN = mdl[c][i]; expP = mdl[c][i]; end
    else if (qsize(c) == 0) begin expStall = 1; expDone = 0; end
    else begin expP = mdl[c][i]; expN = qpop(c); mdl[c][i] = expN; end
    chk({req, " stall"}, int'(renStall), expStall);
    @(posedge clk); #1;
    renValid = 1'b0;
    chk({req, " done"}, int'(renDone), expDone);
    chk({req, " err"}, int'(errFlag), expErr);
    if (expDone) begin
      chk({req, " newTag"}, int'(renNewTag), expN);
      chk({req, " prevTag"}, int'(renPrevTag), expP);
    end
  endtask

  task automatic doLk(string req, int c, int i);
    @(negedge clk);
    lkValid = 1'b1; lkClass = 3'(c); lkIdx = IDX_W'(i);
    #1;
    chk({req, " lookup"}, int'(lkTag), (c == 3) ? i : mdl[c][i]);
  endtask

  task automatic lkAll(string req);
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < ARCH[c]; i++) doLk(req, c, i);
  endtask

  task automatic doSet(string req, int c, int i, int t, int expErr);
    @(negedge clk);
    setValid = 1'b1; setClass = 3'(c); setIdx = IDX_W'(i); setTag = TAG_W'(t);
    @(posedge clk); #1;
    setValid = 1'b0;
    chk({req, " err"}, int'(errFlag), expErr);
    if (c < 3) mdl[c][i] = t;
  endtask

  task automatic doFree(int c, int t);
    @(negedge clk);
    freeValid[c] = 1'b1; freeTag[c] = TAG_W'(t);
    @(posedge clk); #1;
    freeValid = '0;
    qpush(c, t);
  endtask

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 8; i++) mdl[c][i] = i;
    for (int c = 0; c < 3; c++)
      for (int t = ARCH[c]; t < PHYS[c]; t++) qpush(c, t);

    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R1 reset done", int'(renDone), 0);
    chk("R1 reset err", int'(errFlag), 0);
    chk("R1 reset stall", int'(renStall), 0);
    lkAll("R1");

    // R2/R1: drain integer list, tags come out ascending from ARCH
    for (int i = 1; i < 8; i++) doRen("R2", 0, i);
    doRen("R2", 0, 3);
    doRen("R10", 0, 5);           // empty list
    lkAll("R10 unchanged");
    doRen("R3", 0, 0);            // zero register with empty list
    lkAll("R5");                  // other classes untouched

    // floating-point: zero register is index 7
    for (int i = 0; i < 4; i++) doRen("R5", 1, i);
    doRen("R3", 1, 7);
    doRen("R10", 1, 4);

    // condition codes: no zero register
    for (int i = 0; i < 4; i++) doRen("R4", 2, i);
    doFree(2, 0);
    doFree(2, 1);
    doRen("R11", 2, 3);
    doRen("R11", 2, 2);
    doRen("R4", 2, 0);           // stalls again: index 0 still allocates
    lkAll("R5");

    // freed integer tags returned in FIFO order
    doFree(0, 1);
    doFree(0, 3);
    doRen("R11", 0, 6);
    doRen("R3", 0, 0);
    doRen("R11", 0, 7);

    // R7: same-cycle rename and lookup of one entry
    doFree(0, 2);
    @(negedge clk);
    renValid = 1'b1; renClass = 3'd0; renIdx = 3'd4;
    lkValid = 1'b1; lkClass = 3'd0; lkIdx = 3'd4;
    #1;
    chk("R7 old mapping", int'(lkTag), mdl[0][4]);
    @(posedge clk); #1;
    renValid = 1'b0;
    chk("R7 done", int'(renDone), 1);
    chk("R7 newTag", int'(renNewTag), qpop(0));
    mdl[0][4] = int'(renNewTag);
    doLk("R7", 0, 4);

    // R8: set-entry restores a mapping
    doSet("R8", 0, 4, 4, 0);
    doLk("R8", 0, 4);
    // R8: set and rename of the same entry in one cycle, set wins
    doFree(0, 9);
    @(negedge clk);
    renValid = 1'b1; renClass = 3'd0; renIdx = 3'd2;
    setValid = 1'b1; setClass = 3'd0; setIdx = 3'd2; setTag = 4'd2;
    @(posedge clk); #1;
    renValid = 1'b0; setValid = 1'b0;
    chk("R8 newTag", int'(renNewTag), qpop(0));
    chk("R8 prevTag", int'(renPrevTag), mdl[0][2]);
    mdl[0][2] = 2;
    doLk("R8 set wins", 0, 2);

    // R6: misc registers
    for (int i = 0; i < 4; i++) doRen("R6", 3, i);
    doSet("R6 match", 3, 2, 2, 0);
    doSet("R6 mismatch", 3, 1, 5, 1);
    for (int i = 0; i < 4; i++) doLk("R6", 3, i);

    // R9: bad class codes
    doRen("R9", 5, 1);
    doSet("R9", 7, 1, 3, 1);
    @(negedge clk);
    lkValid = 1'b1; lkClass = 3'd6; lkIdx = 3'd0;
    @(posedge clk); #1;
    lkValid = 1'b0;
    chk("R9 lookup err", int'(errFlag), 1);
    @(posedge clk); #1;
    chk("R9 err clears", int'(errFlag), 0);

    lkAll("R5 final");
    doRen("R2", 0, 1);            // list still holds nothing
    doFree(1, 8);
    doRen("R11", 1, 5);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule